// File: doc/BRIEF.md
# Clock Oscillator Trim Register Bank

This block holds the three tuning values of an on-chip clock oscillator and exposes them on a byte-wide register bus. The values are an 8-bit capacitor trim, a 4-bit count of divide-by-two stages after the oscillator, and an 8-bit count of oscillator delay stages above the minimum. All three values drive the oscillator continuously through dedicated output ports.

Two inputs lock parts of the bank against bus writes. While the clock monitor is enabled, the trim cannot be changed. While the frequency-locked loop is enabled, the divider and stage values belong to an external loop filter. The loop filter presents new values together with an update strobe, and the bank stores them. Bus reads therefore always show what the oscillator is being driven with.

Reset recentres the trim. The divider and stage values keep their contents through reset, because the oscillator runs during reset. The divide exponent presented to the oscillator saturates at nine.

Top module: `osc_tune_regs`

## Requirements
- R1: After reset, a read at offset 0 returns 0x80 and `osc_trim` is 0x80.
- R2: A bus write to offset 0 with `mon_en` low updates the trim at the clock edge where `bus_wr` is high. A read at offset 0 and `osc_trim` show the new value after that edge.
- R3: A bus write to offset 0 while `mon_en` is high leaves the trim unchanged.
- R4: A write to offset 1 with `loop_en` low stores `bus_wdata[3:0]` as the divider code. A read at offset 1 returns that code in bits 3:0, with bits 7:4 always zero.
- R5: `osc_div_exp` equals the stored divider code for codes 0 to 9. It equals 9 for codes 0xA to 0xF.
- R6: A write to offset 2 with `loop_en` low stores all 8 data bits as the stage count. A read at offset 2 and `osc_stage` show the stored value.
- R7: While `loop_en` is high, bus writes to offsets 1 and 2 leave the divider and stage values unchanged.
- R8: While `loop_en` is high, a clock edge with `loop_upd` high stores `loop_div` and `loop_stage` as the divider and stage values. Bus reads and the oscillator outputs show them after that edge.
- R9: Asserting and releasing `rst_n` leaves the divider and stage values unchanged.
- R10: Offset 3 reads as zero. A write to offset 3 changes none of the three values.
- R11: `osc_trim` and `osc_stage` always equal the stored trim and stage values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register offset: 0 trim, 1 divider, 2 stage |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| mon_en | input | 1 | Clock monitor enable; blocks trim writes |
| loop_en | input | 1 | Loop enable; hands divider and stage to the loop filter |
| loop_upd | input | 1 | Loop filter update strobe |
| loop_div | input | 4 | Divider code from the loop filter |
| loop_stage | input | 8 | Stage count from the loop filter |
| osc_trim | output | 8 | Trim value to the oscillator |
| osc_div_exp | output | 4 | Saturated divide-by-two count to the oscillator |
| osc_stage | output | 8 | Stage count to the oscillator |

## Verification
On every cycle, the assertions check four things. The trim holds still under a monitor lock. The stage and divider hold still while the loop owns them without an update. A loop update lands on the following edge. The divide exponent never exceeds nine, and the unused read bits stay zero. Only the bench's scenarios can show the rest. These are the sweeps of all trim and divider codes through the bus, values surviving a reset pulse, the recentred trim after reset, and a write to the unused offset leaving all three values intact.

// File: rtl/osc_tune_pkg.sv
package osc_tune_pkg;
  parameter int DATA_W  = 8;
  parameter int ADDR_W  = 2;
  parameter int DIV_W   = 4;
  parameter int DIV_MAX = 9;
  parameter logic [DATA_W-1:0] TRIM_RST = 8'h80;

  parameter logic [ADDR_W-1:0] OFF_TRIM  = 2'd0;
  parameter logic [ADDR_W-1:0] OFF_DIV   = 2'd1;
  parameter logic [ADDR_W-1:0] OFF_STAGE = 2'd2;
endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/osc_trim_reg.sv
module osc_trim_reg
  import osc_tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_trim,
  input  logic              mon_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] trim_q
);
  logic              trim_en;
  logic [DATA_W-1:0] trim_d;

  always_comb begin
    trim_en = wr_trim && !mon_en;
    trim_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      trim_q <= TRIM_RST;
    else if (trim_en) trim_q <= trim_d;
  end

  // R3
  trim_lock_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_trim && mon_en) |=> $stable(trim_q));

  // R2
  trim_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_trim && !mon_en) |=> (trim_q == $past(wdata)));
endmodule

// File: rtl/osc_dco_ctrl.sv
module osc_dco_ctrl
  import osc_tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_div,
  input  logic              wr_stage,
  input  logic [DATA_W-1:0] wdata,
  input  logic              loop_en,
  input  logic              loop_upd,
  input  logic [DIV_W-1:0]  loop_div,
  input  logic [DATA_W-1:0] loop_stage,
  output logic [DIV_W-1:0]  div_q,
  output logic [DATA_W-1:0] stage_q,
  output logic [DIV_W-1:0]  div_exp
);
  localparam logic [DIV_W-1:0] DIV_SAT = DIV_W'(DIV_MAX);

  logic              div_en;
  logic              stage_en;
  logic [DIV_W-1:0]  div_d;
  logic [DATA_W-1:0] stage_d;

  always_comb begin
    if (loop_en) begin
      div_en   = loop_upd;
      stage_en = loop_upd;
      div_d    = loop_div;
      stage_d  = loop_stage;
    end else begin
      div_en   = wr_div;
      stage_en = wr_stage;
      div_d    = wdata[DIV_W-1:0];
      stage_d  = wdata;
    end
  end

  // No reset: the oscillator keeps running through reset.
  always_ff @(posedge clk) begin
    if (div_en)   div_q   <= div_d;
    if (stage_en) stage_q <= stage_d;
  end

  always_comb div_exp = (div_q > DIV_SAT) ? DIV_SAT : div_q;

  // R5
  div_sat_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    div_exp <= DIV_SAT);

  // R7
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (loop_en && !loop_upd) |=> ($stable(div_q) && $stable(stage_q)));

  // R8
  loop_take_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (loop_en && loop_upd) |=>
      (div_q == $past(loop_div) && stage_q == $past(loop_stage)));
endmodule

// File: rtl/osc_tune_regs.sv
module osc_tune_regs
  import osc_tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              mon_en,
  input  logic              loop_en,
  input  logic              loop_upd,
  input  logic [DIV_W-1:0]  loop_div,
  input  logic [DATA_W-1:0] loop_stage,
  output logic [DATA_W-1:0] osc_trim,
  output logic [DIV_W-1:0]  osc_div_exp,
  output logic [DATA_W-1:0] osc_stage
);
  logic              rst_sn;
  logic              wr_trim, wr_div, wr_stage;
  logic [DATA_W-1:0] trim_q, stage_q;
  logic [DIV_W-1:0]  div_q, div_exp;

  osc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  always_comb begin
    wr_trim  = bus_wr && (bus_addr == OFF_TRIM);
    wr_div   = bus_wr && (bus_addr == OFF_DIV);
    wr_stage = bus_wr && (bus_addr == OFF_STAGE);
  end

  osc_trim_reg i_trim (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .wr_trim (wr_trim),
    .mon_en  (mon_en),
    .wdata   (bus_wdata),
    .trim_q  (trim_q)
  );

  osc_dco_ctrl i_dco (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .wr_div     (wr_div),
    .wr_stage   (wr_stage),
    .wdata      (bus_wdata),
    .loop_en    (loop_en),
    .loop_upd   (loop_upd),
    .loop_div   (loop_div),
    .loop_stage (loop_stage),
    .div_q      (div_q),
    .stage_q    (stage_q),
    .div_exp    (div_exp)
  );

  always_comb begin
    case (bus_addr)
      OFF_TRIM:  bus_rdata = trim_q;
      OFF_DIV:   bus_rdata = {{(DATA_W-DIV_W){1'b0}}, div_q};
      OFF_STAGE: bus_rdata = stage_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign osc_trim    = trim_q;
  assign osc_div_exp = div_exp;
  assign osc_stage   = stage_q;

  // R4
  div_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_addr == OFF_DIV) |-> (bus_rdata[DATA_W-1:DIV_W] == '0));

  // R10
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

// File: tb/test_osc_tune_regs.sv
`timescale 1ns/1ps
module test_osc_tune_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       mon_en, loop_en, loop_upd;
  logic [3:0] loop_div;
  logic [7:0] loop_stage;
  logic [7:0] osc_trim, osc_stage;
  logic [3:0] osc_div_exp;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  osc_tune_regs i_osc_tune_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mon_en(mon_en),
    .loop_en(loop_en), .loop_upd(loop_upd), .loop_div(loop_div),
    .loop_stage(loop_stage), .osc_trim(osc_trim),
    .osc_div_exp(osc_div_exp), .osc_stage(osc_stage)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    mon_en = 1'b0; loop_en = 1'b0; loop_upd = 1'b0;
    loop_div = '0; loop_stage = '0;
    do_reset();

    // R1 reset value
    bus_read(2'd0, rd);
    check("R1", rd, 8'h80);
    check("R1", osc_trim, 8'h80);

    // R2 / R3 sweep all trim codes, alternating the monitor lock
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd0, 8'(v));
      bus_read(2'd0, rd);
      check("R2", rd, v);
      check("R11", osc_trim, v);
      mon_en = 1'b1;
      bus_write(2'd0, 8'(v ^ 8'hFF));
      bus_read(2'd0, rd);
      check("R3", rd, v);
      mon_en = 1'b0;
    end

    // R4 / R5 sweep all divider codes
    for (int v = 0; v < 16; v++) begin
      bus_write(2'd1, 8'(8'hF0 | v));
      bus_read(2'd1, rd);
      check("R4", rd, v);
      check("R5", osc_div_exp, (v > 9) ? 9 : v);
    end

    // R6 sweep all stage codes
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd2, 8'(v));
      bus_read(2'd2, rd);
      check("R6", rd, v);
      check("R11", osc_stage, v);
    end

    // R7 writes blocked while loop owns fields
    bus_write(2'd1, 8'h03);
    bus_write(2'd2, 8'h3C);
    loop_en = 1'b1;
    bus_write(2'd1, 8'h07);
    bus_write(2'd2, 8'hC3);
    bus_read(2'd1, rd);
    check("R7", rd, 8'h03);
    bus_read(2'd2, rd);
    check("R7", rd, 8'h3C);
    check("R7", osc_stage, 8'h3C);

    // R8 loop updates, including a saturating code
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      loop_div = (k == 2) ? 4'hC : 4'(k + 5);
      loop_stage = 8'(8'h51 + 8'(k * 37));
      loop_upd = 1'b1;
      @(negedge clk);
      loop_upd = 1'b0;
      bus_read(2'd1, rd);
      check("R8", rd, loop_div);
      bus_read(2'd2, rd);
      check("R8", rd, loop_stage);
      check("R8", osc_stage, loop_stage);
      check("R5", osc_div_exp, (loop_div > 9) ? 9 : loop_div);
    end
    loop_en = 1'b0;

    // R9 divider and stage survive reset; trim recentres (R1)
    bus_write(2'd0, 8'h11);
    bus_write(2'd1, 8'h06);
    bus_write(2'd2, 8'hA5);
    do_reset();
    bus_read(2'd1, rd);
    check("R9", rd, 8'h06);
    bus_read(2'd2, rd);
    check("R9", rd, 8'hA5);
    bus_read(2'd0, rd);
    check("R1", rd, 8'h80);

    // R10 unused offset
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, rd);
    check("R10", rd, 8'h00);
    bus_read(2'd0, rd);
    check("R10", rd, 8'h80);
    bus_read(2'd1, rd);
    check("R10", rd, 8'h06);
    bus_read(2'd2, rd);
    check("R10", rd, 8'hA5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule